// File: doc/BRIEF.md
# Per-Node Receive Request Filter

This block sits in the receive path of a serial-bus link controller. Each incoming asynchronous request brings a source bus ID, a source node number and a flag that says whether it targets the physical request context. From these the block decides three things: whether the request is accepted, whether it goes to the physical context or to the general asynchronous context, and whether its acknowledge is suppressed.

Four 32-bit filter registers hold the per-node permissions: an asynchronous pair (low and high) and a physical pair (low and high). Software reaches each register through a write-one-to-set port, a write-one-to-clear port and a read port. A physical request passes two matches. The first is against the asynchronous filter. The second is against the physical filter, and a request that fails only the second match is routed to the asynchronous context rather than dropped. Requests from another bus skip the per-node match altogether.

Requests enter on a valid/ready stream, and decisions leave on a valid/ready stream through a single register stage. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. A decision that has been offered stays valid and unchanged until `dec_ready` is seen high.

Top module: `node_rx_filter`

## Requirements
- R1: After reset all four filter registers read 0 and `dec_valid` is low. Register index encoding on `set_idx`, `clr_idx` and `rd_idx`: 0 = asynchronous low, 1 = asynchronous high, 2 = physical low, 3 = physical high.
- R2: A set write ORs `set_data` into the register chosen by `set_idx`. Zero bits in `set_data` leave their bits unchanged. `rd_data` shows the new value in the cycle after the write edge.
- R3: A clear write clears every bit that is 1 in `clr_data` in the register chosen by `clr_idx`. Zero bits leave their bits unchanged. If a set and a clear hit the same bit of the same register in one cycle, the bit ends up set.
- R4: For a local request from node n in the range 0..31, the request is accepted exactly when bit n of the asynchronous low register is 1.
- R5: For a local request from node n in the range 32..62, the request is accepted exactly when bit n-32 of the asynchronous high register is 1. A local request from node 63 is never accepted.
- R6: A request counts as local when its bus ID equals 3FFh or equals `local_bus_id`.
- R7: A local physical request goes to the physical context (`dec_route_phys`=1) only when both its asynchronous bit and its physical bit are 1. If the asynchronous bit is 1 and the physical bit is 0, it is accepted and routed to the asynchronous context.
- R8: A non-local, non-physical request is accepted and routed to the asynchronous context, whatever the filter contents.
- R9: A non-local physical request is accepted and routed to the physical context exactly when bit 31 of the physical high register is 1. Otherwise it is rejected.
- R10: `dec_ack_suppress` is 1 exactly when the decision rejects the request. `dec_route_phys` is never 1 on a rejected request.
- R11: The decision appears on `dec_valid` in the cycle after the request handshake. It uses the filter contents from before any set or clear written in the handshake cycle.
- R12: While `dec_valid` is high and `dec_ready` is low, the decision fields stay stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_bus_id | input | 10 | Bus ID of this controller |
| set_we | input | 1 | Set write strobe |
| set_idx | input | 2 | Register chosen by the set write |
| set_data | input | 32 | Bits to set |
| clr_we | input | 1 | Clear write strobe |
| clr_idx | input | 2 | Register chosen by the clear write |
| clr_data | input | 32 | Bits to clear |
| rd_idx | input | 2 | Register chosen for readback |
| rd_data | output | 32 | Current value of the chosen register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_bus | input | 10 | Source bus ID |
| req_node | input | 6 | Source node number |
| req_phys | input | 1 | Request targets the physical context |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_accept | output | 1 | Request accepted |
| dec_route_phys | output | 1 | 1 = physical context, 0 = asynchronous context |
| dec_ack_suppress | output | 1 | Acknowledge is withheld |

## Verification
A decision is due on the falling edge right after the rising edge that takes its request, because one register lies on the way. A readback value is due on the falling edge after the rising edge of the write. The bench model moves on the same rising edges as the design: it first takes any handshake, using the filter contents from before that edge, and then applies the writes with set given priority. Outputs are compared against the model on every falling edge, so each result is checked exactly in the cycle it is due. While back-pressure holds a decision, that decision is checked for stability on every cycle it is held.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [1:0] {
    NF_ASYNC_LO = 2'd0,
    NF_ASYNC_HI = 2'd1,
    NF_PHYS_LO  = 2'd2,
    NF_PHYS_HI  = 2'd3
  } nf_reg_e;

  localparam int NF_NUM_REGS = 4;

  typedef struct packed {
    logic accept;
    logic route_phys;
    logic ack_suppress;
  } nf_dec_t;
endpackage

// File: rtl/nf_filt_reg.sv
module nf_filt_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_hit,
  input  logic [W-1:0] set_bits,
  input  logic         clr_hit,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_mask, clr_mask;

  assign set_mask = set_hit ? set_bits : '0;
  assign clr_mask = clr_hit ? clr_bits : '0;

  // clear applied first, set ORed after: set wins on a shared bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((q & $past(set_bits)) == $past(set_bits)));

  p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_hit) |=> ((q & $past(clr_bits)) == '0));

  p_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit && !clr_hit) |=> $stable(q));
endmodule

// File: rtl/nf_locality.sv
module nf_locality #(
  parameter int BUS_W = 10
) (
  input  logic [BUS_W-1:0] bus_id,
  input  logic [BUS_W-1:0] local_bus_id,
  output logic             is_local
);
  logic own_alias, own_match;

  assign own_alias = &bus_id;
  assign own_match = (bus_id == local_bus_id);
  assign is_local  = own_alias || own_match;
endmodule

// File: rtl/nf_match.sv
module nf_match
  import nf_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int REG_W  = 32
) (
  input  logic [REG_W-1:0]  async_lo,
  input  logic [REG_W-1:0]  async_hi,
  input  logic [REG_W-1:0]  phys_lo,
  input  logic [REG_W-1:0]  phys_hi,
  input  logic              is_local,
  input  logic [NODE_W-1:0] node,
  input  logic              phys,
  output nf_dec_t           dec
);
  localparam int IDX_W = $clog2(REG_W);

  logic [IDX_W-1:0] bit_sel;
  logic             upper_half, bcast;
  logic             async_bit, phys_bit, remote_phys_ok;

  assign bit_sel        = node[IDX_W-1:0];
  assign upper_half     = node[NODE_W-1];
  assign bcast          = &node;
  assign remote_phys_ok = phys_hi[REG_W-1];

  always_comb begin
    async_bit = upper_half ? async_hi[bit_sel] : async_lo[bit_sel];
    phys_bit  = upper_half ? phys_hi[bit_sel]  : phys_lo[bit_sel];
    if (bcast) begin
      async_bit = 1'b0;
      phys_bit  = 1'b0;
    end
  end

  always_comb begin
    if (is_local) begin
      dec.accept     = async_bit;
      dec.route_phys = phys && async_bit && phys_bit;
    end else if (phys) begin
      dec.accept     = remote_phys_ok;
      dec.route_phys = remote_phys_ok;
    end else begin
      dec.accept     = 1'b1;
      dec.route_phys = 1'b0;
    end
    dec.ack_suppress = !dec.accept;
  end

  always_comb begin
    if (is_local && bcast) a_bcast_r5: assert (!dec.accept);
  end
endmodule

// File: rtl/node_rx_filter.sv
module node_rx_filter
  import nf_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int BUS_W  = 10,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  local_bus_id,
  input  logic              set_we,
  input  logic [1:0]        set_idx,
  input  logic [REG_W-1:0]  set_data,
  input  logic              clr_we,
  input  logic [1:0]        clr_idx,
  input  logic [REG_W-1:0]  clr_data,
  input  logic [1:0]        rd_idx,
  output logic [REG_W-1:0]  rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [NODE_W-1:0] req_node,
  input  logic              req_phys,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  output logic              dec_route_phys,
  output logic              dec_ack_suppress
);
  logic [REG_W-1:0] filt [NF_NUM_REGS];

  for (genvar i = 0; i < NF_NUM_REGS; i++) begin : g_reg
    nf_filt_reg #(.W(REG_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_hit  (set_we && (set_idx == i[1:0])),
      .set_bits (set_data),
      .clr_hit  (clr_we && (clr_idx == i[1:0])),
      .clr_bits (clr_data),
      .q        (filt[i])
    );
  end

  assign rd_data = filt[rd_idx];

  logic    is_local;
  nf_dec_t dec_d, dec_q;
  logic    take;

  nf_locality #(.BUS_W(BUS_W)) u_loc (
    .bus_id       (req_bus),
    .local_bus_id (local_bus_id),
    .is_local     (is_local)
  );

  nf_match #(.NODE_W(NODE_W), .REG_W(REG_W)) u_match (
    .async_lo (filt[NF_ASYNC_LO]),
    .async_hi (filt[NF_ASYNC_HI]),
    .phys_lo  (filt[NF_PHYS_LO]),
    .phys_hi  (filt[NF_PHYS_HI]),
    .is_local (is_local),
    .node     (req_node),
    .phys     (req_phys),
    .dec      (dec_d)
  );

  assign req_ready = !dec_valid || dec_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_q     <= '0;
    end else if (take) begin
      dec_valid <= 1'b1;
      dec_q     <= dec_d;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  assign dec_accept       = dec_q.accept;
  assign dec_route_phys   = dec_q.route_phys;
  assign dec_ack_suppress = dec_q.ack_suppress;

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> dec_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_q)));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !req_ready);

  p_route_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_route_phys) |-> dec_accept);

  p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_ack_suppress != dec_accept));
endmodule

// File: tb/sim_node_rx_filter.sv
module sim_node_rx_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  local_bus_id = 10'h2A5;
  logic        set_we = 0, clr_we = 0;
  logic [1:0]  set_idx = 0, clr_idx = 0, rd_idx = 0;
  logic [31:0] set_data = 0, clr_data = 0;
  logic [31:0] rd_data;
  logic        req_valid = 0, req_ready, req_phys = 0;
  logic [9:0]  req_bus = 0;
  logic [5:0]  req_node = 0;
  logic        dec_valid, dec_ready = 1, dec_accept, dec_route_phys, dec_ack_suppress;

  always #5 clk = ~clk;

  node_rx_filter u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur = "R1";

  // behavioural reference
  logic [31:0] m [4];
  logic ev, ea, er, es;

  function automatic void model_decide(input logic [9:0] bus, input int node,
                                       input logic phys);
    logic loc, ab, pb;
    loc = (bus == 10'h3FF) || (bus == local_bus_id);
    if (loc) begin
      ab = 0; pb = 0;
      if (node < 32) begin ab = m[0][node]; pb = m[2][node]; end
      else if (node < 63) begin ab = m[1][node-32]; pb = m[3][node-32]; end
      ea = ab; er = phys && ab && pb;
    end else if (phys) begin
      ea = m[3][31]; er = m[3][31];
    end else begin
      ea = 1; er = 0;
    end
    es = !ea;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m[i] = '0;
      ev = 0; ea = 0; er = 0; es = 0;
    end else begin
      if (req_valid && (!ev || dec_ready)) begin
        model_decide(req_bus, int'(req_node), req_phys);
        ev = 1;
      end else if (dec_ready) ev = 0;
      if (clr_we) m[clr_idx] = m[clr_idx] & ~clr_data;
      if (set_we) m[set_idx] = m[set_idx] | set_data;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("dec_valid", 32'(dec_valid), 32'(ev));
      chk("req_ready", 32'(req_ready), 32'(!ev || dec_ready));
      chk("rd_data", rd_data, m[rd_idx]);
      if (ev) begin
        chk("accept", 32'(dec_accept), 32'(ea));
        chk("route_phys", 32'(dec_route_phys), 32'(er));
        chk("ack_suppress", 32'(dec_ack_suppress), 32'(es));
      end
    end
  end

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic idle;
    set_we = 0; clr_we = 0; req_valid = 0;
  endtask

  task automatic wset(input logic [1:0] idx, input logic [31:0] d);
    step; idle; set_we = 1; set_idx = idx; set_data = d; rd_idx = idx;
    step; idle;
  endtask

  task automatic wclr(input logic [1:0] idx, input logic [31:0] d);
    step; idle; clr_we = 1; clr_idx = idx; clr_data = d; rd_idx = idx;
    step; idle;
  endtask

  task automatic send(input logic [9:0] bus, input logic [5:0] node, input logic phys);
    step; idle; req_valid = 1; req_bus = bus; req_node = node; req_phys = phys;
    step; idle;
  endtask

  initial begin
    // R1: reset state, readback of every register
    #23 rst_n = 1;
    for (int i = 0; i < 4; i++) begin step; rd_idx = 2'(i); end
    step;
    // R2: set with pattern, then zeros change nothing
    cur = "R2";
    wset(0, 32'hA5A5_0F0F);
    wset(0, 32'h0000_0000);
    wset(0, 32'h0000_0010);
    // R3: clear, and set/clear on the same bit in one cycle
    cur = "R3";
    wclr(0, 32'h0000_000F);
    wclr(0, 32'h0);
    step; idle; set_we = 1; clr_we = 1; set_idx = 1; clr_idx = 1;
    set_data = 32'h0000_00FF; clr_data = 32'h0000_0F0F; rd_idx = 1;
    step; idle;
    wclr(1, 32'hFFFF_FFFF);
    // R4: low node mapping
    cur = "R4";
    wset(0, 32'h8000_0021);
    send(10'h3FF, 6'd0, 0); send(10'h3FF, 6'd5, 0);
    send(10'h3FF, 6'd31, 0); send(10'h3FF, 6'd1, 0);
    // R5: high node mapping, broadcast node never matches
    cur = "R5";
    wset(1, 32'hFFFF_FFFF);
    send(10'h3FF, 6'd32, 0); send(10'h3FF, 6'd62, 0); send(10'h3FF, 6'd63, 0);
    wclr(1, 32'h0000_0002);
    send(10'h3FF, 6'd33, 0);
    // R6: locality by alias and by own bus ID
    cur = "R6";
    send(10'h2A5, 6'd1, 0); send(10'h2A5, 6'd0, 0); send(10'h3FE, 6'd1, 0);
    // R7: two-stage match with fallback
    cur = "R7";
    wset(2, 32'h0000_0001);
    send(10'h3FF, 6'd0, 1); send(10'h3FF, 6'd5, 1); send(10'h3FF, 6'd2, 1);
    // R8: remote async ignores filters
    cur = "R8";
    send(10'h001, 6'd2, 0); send(10'h100, 6'd63, 0);
    // R9: remote physical gated by bit 31 of physical high
    cur = "R9";
    send(10'h001, 6'd0, 1);
    wset(3, 32'h8000_0000);
    send(10'h001, 6'd0, 1);
    // R10: rejection raises suppress
    cur = "R10";
    send(10'h3FF, 6'd7, 1);
    // R11: write in handshake cycle affects only later requests
    cur = "R11";
    step; idle; req_valid = 1; req_bus = 10'h3FF; req_node = 6'd9; req_phys = 0;
    set_we = 1; set_idx = 0; set_data = 32'h0000_0200;
    step; idle; req_valid = 1;
    step; idle;
    // R12: back-pressure
    cur = "R12";
    step; idle; dec_ready = 0; req_valid = 1; req_node = 6'd9;
    step; req_node = 6'd3;
    repeat (4) step;
    dec_ready = 1; step; idle;
    // mixed random traffic
    cur = "R2";
    for (int k = 0; k < 400; k++) begin
      step;
      cur = (k % 2) ? "R7" : "R12";
      set_we = ($urandom % 4) == 0; set_idx = 2'($urandom); set_data = $urandom;
      clr_we = ($urandom % 4) == 0; clr_idx = 2'($urandom); clr_data = $urandom;
      rd_idx = 2'($urandom);
      req_valid = $urandom % 2; req_phys = $urandom % 2;
      req_node = 6'($urandom);
      req_bus = ($urandom % 3 == 0) ? 10'h3FF : (($urandom % 2) ? local_bus_id : 10'($urandom));
      dec_ready = ($urandom % 4) != 0;
    end
    step; idle; dec_ready = 1;
    repeat (3) step;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule